// File: doc/BRIEF.md
# Device-Side Command Mailbox Controller

This block is the device end of a command mailbox. A host reaches it through a simple word-wide memory-mapped bus and sees a small set of registers. There is a read-only capability word that gives the payload buffer size as a power-of-two exponent. There is a control word whose bit 0 is the doorbell. A command word holds an opcode and a payload-length field, and a status word holds a 16-bit return code. A device status word carries the mailbox-ready, fatal and firmware-halt flags. The upper half of the address space is a payload window into a local buffer.

The host fills the command word and the input payload, then sets the doorbell. The block then owns the mailbox. It pulses a start strobe toward a local command engine and shows it the opcode and input length. It lets that engine read and write the payload buffer. When the engine reports completion, the block records the return code and the output length, then drops the doorbell. From that moment the device cannot change the command, status or payload contents until the next doorbell.

Top module: `cmd_mailbox`

## Requirements
- R1: The capability word (register index 0) reads the buffer exponent PAY_EXP in bits [4:0], with all other bits zero. The buffer size is 2^PAY_EXP bytes, and PAY_EXP must be at least 8.
- R2: The ready flag is bit 4 of the device status word (register index 4). It reads 0 until READY_DELAY rising edges have passed after reset is released, and from then on it stays 1. A doorbell request made while ready is 0 is dropped.
- R3: A bus write to the control word (index 1) with bit 0 set, while the mailbox is idle and ready, sets the doorbell (control bit 0 reads 1). On the next cycle exe_start is high for exactly one cycle, and exe_opcode/exe_in_len show the command word's opcode [15:0] and length [36:16].
- R4: While the doorbell is set, a host write of 0 to the doorbell has no effect, and host writes to the command word or to the payload window are ignored.
- R5: exe_done is accepted in any cycle after the start cycle while the doorbell is set. At that edge the status word [15:0] takes exe_rc and the doorbell clears. If exe_rc is 0 (success), the command length field takes exe_out_len limited to 2^PAY_EXP; otherwise it takes 0. The opcode field is kept.
- R6: Once the doorbell is clear, the device side cannot change the status word, the command word or the payload buffer. exe_pl_we has no effect while the doorbell is clear.
- R7: Payload window addresses have the top address bit set. The lower bits give a 64-bit word index, and word i holds buffer bytes 8i to 8i+7. Indexes at or above 2^PAY_EXP/8 read zero, and writes to them are dropped. The engine port exe_pl_idx addresses the same words.
- R8: Bits 0 and 1 of the device status word follow the dev_fatal and dev_fw_halt inputs in the same cycle.
- R9: exe_done while the doorbell is clear has no effect on any register.
- R10: Register indexes 5 and up in the lower half of the address space read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | PAY_EXP-1 | Host word address: top bit selects the payload window |
| bus_wdata | input | 64 | Host write data |
| bus_rdata | output | 64 | Host read data for bus_addr, combinational |
| dev_fatal | input | 1 | Device fatal-error flag |
| dev_fw_halt | input | 1 | Device firmware-halt flag |
| exe_start | output | 1 | One-cycle command start strobe |
| exe_opcode | output | 16 | Opcode of the command in flight |
| exe_in_len | output | 21 | Input payload length in bytes |
| exe_done | input | 1 | Command completion strobe |
| exe_rc | input | 16 | Return code given with exe_done |
| exe_out_len | input | 21 | Output payload length given with exe_done |
| exe_pl_we | input | 1 | Engine payload write strobe |
| exe_pl_idx | input | PAY_EXP-3 | Engine payload word index |
| exe_pl_wdata | input | 64 | Engine payload write data |
| exe_pl_rdata | output | 64 | Engine payload read data, combinational |

## Verification
The assertions assume that the command word may legitimately change between commands only through a host write. The freeze property therefore excuses a cycle that follows a host command write, and it excuses nothing else. They also assume the engine's completion strobe can arrive at any time, including when no command is in flight. So the properties only tie doorbell clearing to an accepted strobe. The stimulus changes every input only on the falling clock edge. It sends deliberately stray completions and payload writes while idle, and it keeps reported lengths within the 21-bit field, including its all-ones value.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
    localparam int DATA_W = 64;
    localparam int OPC_W  = 16;
    localparam int LEN_W  = 21;
    localparam int RC_W   = 16;
    localparam int EXP_W  = 5;

    localparam logic [RC_W-1:0] RC_OK = '0;

    typedef enum logic [2:0] {
        RG_CAPS  = 3'd0,
        RG_CTRL  = 3'd1,
        RG_CMD   = 3'd2,
        RG_STAT  = 3'd3,
        RG_DEVST = 3'd4
    } reg_sel_e;

    localparam int DS_FATAL = 0;
    localparam int DS_HALT  = 1;
    localparam int DS_READY = 4;

    // command word: opcode [15:0], length [36:16]
    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [OPC_W-1:0] opc;
    } cmd_t;

    localparam int CMD_W = LEN_W + OPC_W;

    function automatic logic [DATA_W-1:0] cmd_to_word(cmd_t c);
        return {{(DATA_W-CMD_W){1'b0}}, c};
    endfunction

    function automatic cmd_t word_to_cmd(logic [DATA_W-1:0] w);
        return cmd_t'(w[CMD_W-1:0]);
    endfunction

    function automatic logic [LEN_W-1:0] limit_len(logic [LEN_W-1:0] v,
                                                   logic [LEN_W-1:0] lim);
        return (v > lim) ? lim : v;
    endfunction
endpackage

// File: rtl/cm_ready_timer.sv
module cm_ready_timer #(
    parameter int DELAY = 16,
    localparam int CW = $clog2(DELAY + 2)
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt != CW'(DELAY))
            cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == CW'(DELAY));
endmodule

// File: rtl/cm_payload_ram.sv
module cm_payload_ram #(
    parameter int WORDS = 32,
    parameter int DW    = 64,
    localparam int IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/cm_seq.sv
module cm_seq
    import cmd_mailbox_pkg::*;
#(
    parameter int PAY_BYTES = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ready,
    input  logic             ring_req,
    input  logic             cmd_we,
    input  cmd_t             cmd_wval,
    input  logic             done,
    input  logic [RC_W-1:0]  done_rc,
    input  logic [LEN_W-1:0] done_len,
    output logic             doorbell,
    output logic             issue,
    output cmd_t             cmd_q,
    output logic [RC_W-1:0]  rc_q
);
    localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(PAY_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            doorbell <= 1'b0;
            issue    <= 1'b0;
            cmd_q    <= '0;
            rc_q     <= RC_OK;
        end else begin
            issue <= 1'b0;
            if (!doorbell) begin
                if (cmd_we)
                    cmd_q <= cmd_wval;
                if (ring_req && ready) begin
                    doorbell <= 1'b1;
                    issue    <= 1'b1;
                end
            end else if (!issue && done) begin
                rc_q      <= done_rc;
                cmd_q.len <= (done_rc == RC_OK) ? limit_len(done_len, LEN_LIM) : '0;
                doorbell  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import cmd_mailbox_pkg::*;
#(
    parameter int PAY_EXP     = 8,
    parameter int READY_DELAY = 16,
    localparam int AW  = PAY_EXP - 1,
    localparam int PWA = PAY_EXP - 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dev_fatal,
    input  logic              dev_fw_halt,
    output logic              exe_start,
    output logic [OPC_W-1:0]  exe_opcode,
    output logic [LEN_W-1:0]  exe_in_len,
    input  logic              exe_done,
    input  logic [RC_W-1:0]   exe_rc,
    input  logic [LEN_W-1:0]  exe_out_len,
    input  logic              exe_pl_we,
    input  logic [PWA-1:0]    exe_pl_idx,
    input  logic [DATA_W-1:0] exe_pl_wdata,
    output logic [DATA_W-1:0] exe_pl_rdata
);
    localparam int PAY_BYTES = 1 << PAY_EXP;
    localparam int PAY_WORDS = PAY_BYTES / 8;

    logic            mbx_ready;
    logic            doorbell;
    logic            issue;
    cmd_t            cmd_q;
    logic [RC_W-1:0] rc_q;

    logic            in_window;
    logic [AW-2:0]   low_idx;
    logic            win_hit;
    logic            host_cmd_we;
    logic            host_ring;
    logic            ram_we;
    logic [PWA-1:0]  ram_widx;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] host_pl_rd;

    assign in_window   = bus_addr[AW-1];
    assign low_idx     = bus_addr[AW-2:0];
    assign win_hit     = in_window && (low_idx < (AW-1)'(PAY_WORDS));
    assign host_cmd_we = bus_we && !in_window && (low_idx == (AW-1)'(RG_CMD));
    assign host_ring   = bus_we && !in_window && (low_idx == (AW-1)'(RG_CTRL)) && bus_wdata[0];

    cm_ready_timer #(.DELAY(READY_DELAY)) u_rdy (
        .clk   (clk),
        .rst   (rst),
        .ready (mbx_ready)
    );

    cm_seq #(.PAY_BYTES(PAY_BYTES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ready    (mbx_ready),
        .ring_req (host_ring),
        .cmd_we   (host_cmd_we),
        .cmd_wval (word_to_cmd(bus_wdata)),
        .done     (exe_done),
        .done_rc  (exe_rc),
        .done_len (exe_out_len),
        .doorbell (doorbell),
        .issue    (issue),
        .cmd_q    (cmd_q),
        .rc_q     (rc_q)
    );

    // ownership: host writes while idle, engine writes while doorbell set
    always_comb begin
        if (doorbell) begin
            ram_we    = exe_pl_we;
            ram_widx  = exe_pl_idx;
            ram_wdata = exe_pl_wdata;
        end else begin
            ram_we    = bus_we && win_hit;
            ram_widx  = low_idx[PWA-1:0];
            ram_wdata = bus_wdata;
        end
    end

    cm_payload_ram #(.WORDS(PAY_WORDS), .DW(DATA_W)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .we      (ram_we),
        .widx    (ram_widx),
        .wdata   (ram_wdata),
        .ridx_a  (low_idx[PWA-1:0]),
        .rdata_a (host_pl_rd),
        .ridx_b  (exe_pl_idx),
        .rdata_b (exe_pl_rdata)
    );

    assign exe_start  = issue;
    assign exe_opcode = cmd_q.opc;
    assign exe_in_len = cmd_q.len;

    always_comb begin
        bus_rdata = '0;
        if (in_window) begin
            if (win_hit) bus_rdata = host_pl_rd;
        end else begin
            case (low_idx)
                (AW-1)'(RG_CAPS):  bus_rdata[EXP_W-1:0] = EXP_W'(PAY_EXP);
                (AW-1)'(RG_CTRL):  bus_rdata[0] = doorbell;
                (AW-1)'(RG_CMD):   bus_rdata = cmd_to_word(cmd_q);
                (AW-1)'(RG_STAT):  bus_rdata[RC_W-1:0] = rc_q;
                (AW-1)'(RG_DEVST): begin
                    bus_rdata[DS_FATAL] = dev_fatal;
                    bus_rdata[DS_HALT]  = dev_fw_halt;
                    bus_rdata[DS_READY] = mbx_ready;
                end
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cm_checker.sv
module cm_checker
    import cmd_mailbox_pkg::*;
#(
    parameter int PAY_BYTES = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             db,
    input logic             ready,
    input logic             start,
    input logic             done,
    input logic             host_cmd_we,
    input logic [RC_W-1:0]  rc,
    input logic [CMD_W-1:0] cmd
);
    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    a_r3_start_in_flight: assert property (@(posedge clk) disable iff (rst)
        start |-> db);

    a_r2_ready_holds: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    a_r2_ring_needs_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(db) |-> $past(ready));

    a_r5_clear_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(db) |-> $past(done));

    a_r5_len_limited: assert property (@(posedge clk) disable iff (rst)
        $fell(db) |-> (cmd[CMD_W-1:OPC_W] <= LEN_W'(PAY_BYTES)));

    a_r6_status_frozen: assert property (@(posedge clk) disable iff (rst)
        (!db && !$past(db)) |-> $stable(rc));

    a_r6_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
        (!db && !$past(db) && !$past(host_cmd_we)) |-> $stable(cmd));
endmodule

bind cmd_mailbox cm_checker #(.PAY_BYTES(PAY_BYTES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .db          (doorbell),
    .ready       (mbx_ready),
    .start       (exe_start),
    .done        (exe_done),
    .host_cmd_we (host_cmd_we),
    .rc          (rc_q),
    .cmd         (cmd_q)
);

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int PEXP  = 8;
    localparam int RDLY  = 12;
    localparam int AW    = PEXP - 1;
    localparam int PWA   = PEXP - 3;
    localparam int PBYTES = 1 << PEXP;
    localparam int PWORDS = PBYTES / 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic dev_fatal = 1'b0, dev_fw_halt = 1'b0;
    logic exe_start;
    logic [15:0] exe_opcode;
    logic [20:0] exe_in_len;
    logic exe_done = 1'b0;
    logic [15:0] exe_rc = '0;
    logic [20:0] exe_out_len = '0;
    logic exe_pl_we = 1'b0;
    logic [PWA-1:0] exe_pl_idx = '0;
    logic [63:0] exe_pl_wdata = '0;
    logic [63:0] exe_pl_rdata;

    int checks = 0, failures = 0;
    logic [63:0] model [PWORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_mailbox #(.PAY_EXP(PEXP), .READY_DELAY(RDLY)) u0 (
        .clk, .rst, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .dev_fatal, .dev_fw_halt, .exe_start, .exe_opcode, .exe_in_len,
        .exe_done, .exe_rc, .exe_out_len, .exe_pl_we, .exe_pl_idx,
        .exe_pl_wdata, .exe_pl_rdata
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [63:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    function automatic logic [AW-1:0] win(input int i);
        return AW'((1 << (AW-1)) + i);
    endfunction

    function automatic logic [63:0] pat(input int i, input int salt);
        return {32'(i * 32'h9E37 + salt), ~32'(i + salt)};
    endfunction

    function automatic logic [63:0] cmdw(input logic [15:0] o, input logic [20:0] l);
        return {27'b0, l, o};
    endfunction

    task automatic run_cmd(input logic [15:0] opc, input logic [20:0] inl,
                           input logic [15:0] rc, input logic [20:0] outl, input int wait_cyc);
        logic [63:0] d;
        logic [20:0] exp_len;
        wr(AW'(2), cmdw(opc, inl));
        wr(AW'(1), 64'h1);
        chk(exe_start === 1'b1, "R3 start", 64'(exe_start), 64'h1);
        chk(exe_opcode === opc && exe_in_len === inl, "R3 opcode/len", {exe_in_len, exe_opcode}, {inl, opc});
        rd(AW'(1), d);
        chk(d === 64'h1, "R3 doorbell set", d, 64'h1);
        wr(AW'(2), 64'hFFFF_FFFF_FFFF_FFFF);
        chk(exe_start === 1'b0, "R3 start one cycle", 64'(exe_start), 64'h0);
        wr(win(0), 64'hDEAD_BEEF_0000_0001);
        wr(AW'(1), 64'h0);
        rd(AW'(1), d);
        chk(d === 64'h1, "R4 doorbell kept", d, 64'h1);
        rd(AW'(2), d);
        chk(d === cmdw(opc, inl), "R4 cmd ignored", d, cmdw(opc, inl));
        rd(win(0), d);
        chk(d === model[0], "R4 payload ignored", d, model[0]);
        for (int w = 0; w < wait_cyc; w++) begin
            exe_pl_we = 1'b1; exe_pl_idx = PWA'(w + 2); exe_pl_wdata = pat(w + 2, opc);
            model[w + 2] = pat(w + 2, opc);
            @(posedge clk); @(negedge clk);
            exe_pl_we = 1'b0;
        end
        exe_done = 1'b1; exe_rc = rc; exe_out_len = outl;
        @(posedge clk); @(negedge clk);
        exe_done = 1'b0;
        exp_len = (rc != 16'h0) ? 21'h0 : ((outl > 21'(PBYTES)) ? 21'(PBYTES) : outl);
        rd(AW'(1), d);
        chk(d === 64'h0, "R5 doorbell cleared", d, 64'h0);
        rd(AW'(3), d);
        chk(d === {48'h0, rc}, "R5 return code", d, {48'h0, rc});
        rd(AW'(2), d);
        chk(d === cmdw(opc, exp_len), "R5 out length", d, cmdw(opc, exp_len));
        if (wait_cyc > 0) begin
            rd(win(2), d);
            chk(d === model[2], "R7 engine write seen by host", d, model[2]);
        end
        // stray engine activity after completion
        exe_pl_we = 1'b1; exe_pl_idx = PWA'(2); exe_pl_wdata = 64'h5555;
        exe_done = 1'b1; exe_rc = 16'h7777; exe_out_len = 21'h3;
        @(posedge clk); @(negedge clk);
        exe_pl_we = 1'b0; exe_done = 1'b0;
        rd(win(2), d);
        chk(d === model[2], "R6 payload frozen", d, model[2]);
        rd(AW'(3), d);
        chk(d === {48'h0, rc}, "R9 stray done status", d, {48'h0, rc});
        rd(AW'(2), d);
        chk(d === cmdw(opc, exp_len), "R9 stray done cmd", d, cmdw(opc, exp_len));
        rd(AW'(1), d);
        chk(d === 64'h0, "R9 no doorbell", d, 64'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 and reset state while still in reset
        rd(AW'(0), d);
        chk(d === 64'(PEXP), "R1 caps", d, 64'(PEXP));
        rd(AW'(4), d);
        chk(d === 64'h0, "R2 ready low in reset", d, 64'h0);
        rd(AW'(1), d);
        chk(d === 64'h0, "R3 doorbell reset", d, 64'h0);
        rst = 1'b0;
        // ring attempts during edges 1..4 must be dropped (R2)
        bus_we = 1'b1; bus_addr = AW'(1); bus_wdata = 64'h1;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk); @(negedge clk);
            if (k <= 4) begin
                #1;
                chk(bus_rdata === 64'h0, "R2 ring before ready", bus_rdata, 64'h0);
                if (k == 4) begin bus_we = 1'b0; bus_addr = AW'(4); end
            end else begin
                #1;
                chk(bus_rdata[4] === (k >= RDLY), "R2 ready timing", 64'(bus_rdata[4]), 64'(k >= RDLY));
            end
        end
        // R8 sweep
        for (int m = 0; m < 4; m++) begin
            dev_fatal = m[0]; dev_fw_halt = m[1];
            rd(AW'(4), d);
            chk(d === (64'h10 | 64'(m)), "R8 device flags", d, 64'h10 | 64'(m));
        end
        dev_fatal = 1'b0; dev_fw_halt = 1'b0;
        // R7 sweep over full window
        for (int i = 0; i < (1 << (AW-1)); i++) wr(win(i), pat(i, 1));
        for (int i = 0; i < PWORDS; i++) model[i] = pat(i, 1);
        for (int i = 0; i < (1 << (AW-1)); i++) begin
            logic [63:0] e;
            e = (i < PWORDS) ? pat(i, 1) : 64'h0;
            rd(win(i), d);
            chk(d === e, "R7 window read", d, e);
        end
        for (int i = 0; i < PWORDS; i++) begin
            exe_pl_idx = PWA'(i); #1;
            chk(exe_pl_rdata === model[i], "R7 engine read", exe_pl_rdata, model[i]);
        end
        // R10 unmapped registers
        for (int r = 5; r < (1 << (AW-1)); r++) wr(AW'(r), 64'hA5A5_A5A5_A5A5_A5A5);
        for (int r = 5; r < (1 << (AW-1)); r++) begin
            rd(AW'(r), d);
            chk(d === 64'h0, "R10 unmapped", d, 64'h0);
        end
        rd(AW'(1), d);
        chk(d === 64'h0, "R10 no side effect", d, 64'h0);
        // command sweep (R3-R6, R9)
        run_cmd(16'h0001, 21'd0,    16'h0, 21'd0,        0);
        run_cmd(16'h4300, 21'd16,   16'h0, 21'd8,        1);
        run_cmd(16'h0400, 21'd256,  16'h0, 21'd255,      2);
        run_cmd(16'hBEEF, 21'd64,   16'h0, 21'd256,      3);
        run_cmd(16'h1234, 21'd8,    16'h0, 21'd257,      1);
        run_cmd(16'hFFFF, 21'h1FFFFF, 16'h0, 21'h1FFFFF, 4);
        run_cmd(16'h0102, 21'd32,   16'h0005, 21'd40,    2);
        run_cmd(16'h0A0B, 21'd1,    16'hFFFF, 21'd0,     0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule